// File: doc/BRIEF.md
# Operand Barrel Shifter with Carry-Out

This block forms the second ALU operand from a data word and a shift request, and reports the shifter carry that the flag logic consumes. It is purely combinational: a new result and carry appear in the same cycle that the inputs change, and it holds no state. Five shift kinds are supported: logical left, logical right, arithmetic right, rotate right, and a one-position rotate right through the carry flag.

The shift amount comes from one of two places. It is either a small immediate field or the low bits of a register value, and a select input chooses between them. The upper bits of the register value are discarded. The datapath is one logarithmic right-rotator. Left shifts reuse it by reversing the bit order before and after the rotation. A mask stage then turns the rotation into zero-fill or sign-fill shifts.

Top module: `opnd_shifter`

## Requirements
- R1: Kind code 0 (left shift) with amount n in 1..31 gives data << n with zeros in the low n bits, and the carry-out is data bit 32-n.
- R2: Kind code 1 (logical right) with amount n in 1..31 gives data >> n with zeros in the top n bits, and the carry-out is data bit n-1.
- R3: Kind code 2 (arithmetic right) with amount n in 1..31 fills the top n bits with copies of data bit 31, and the carry-out is data bit n-1.
- R4: Kind code 3 (rotate right) with amount n in 1..31 re-enters bits leaving bit 0 at bit 31, keeps the number of set bits, and the carry-out is result bit 31 (data bit n-1).
- R5: Kind code 4 (rotate through carry) ignores the amount. The result is {carry_i, data[31:1]} and the carry-out is data bit 0.
- R6: For kind codes 0 to 3 with an amount of zero, the result equals the data and the carry-out equals carry_i.
- R7: With amt_from_reg_i = 0 the amount is amt_imm_i. With amt_from_reg_i = 1 it is bits [4:0] of amt_reg_i, and bits [31:5] have no effect on either output.
- R8: Kind codes 5, 6 and 7 are unused. They pass the data through unchanged with the carry-out equal to carry_i, for any amount.
- R9: The outputs follow the inputs combinationally, with no clock or pipeline stage, so they are valid within the cycle the inputs are applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| data_i | input | 32 | Word to be shifted |
| kind_i | input | 3 | Shift kind: 0 left, 1 logical right, 2 arithmetic right, 3 rotate right, 4 rotate through carry |
| amt_from_reg_i | input | 1 | 1 takes the amount from amt_reg_i, 0 from amt_imm_i |
| amt_imm_i | input | 5 | Immediate shift amount 0..31 |
| amt_reg_i | input | 32 | Register value whose low 5 bits give the amount |
| carry_i | input | 1 | Current carry flag |
| result_o | output | 32 | Shifted operand |
| carry_o | output | 1 | Shifter carry-out |

## Verification
The embedded immediate assertions are evaluated whenever the inputs settle. They check the following properties on every input pattern: the zeroed low bits after a left shift, the clear top bit after a nonzero logical right shift, sign retention for arithmetic right, the preserved set-bit count for rotate, the carry-flag placement for the through-carry rotate, pass-through at amount zero and for unused codes, and the register-source amount truncation. What the assertions cannot establish is the exact value of every result bit and carry for each kind. Those are compared by the bench against an independent bit-by-bit model, at amounts 0, 1, 2 and 31, across several data patterns, both carry inputs and both amount sources.

// File: rtl/bsh_pkg.sv
`timescale 1ns/1ps
package bsh_pkg;

   typedef enum logic [2:0] {
      SK_LSL = 3'd0,
      SK_LSR = 3'd1,
      SK_ASR = 3'd2,
      SK_ROR = 3'd3,
      SK_RRX = 3'd4
   } shift_kind_e;

endpackage

// File: rtl/bsh_amt_sel.sv
`timescale 1ns/1ps
module bsh_amt_sel #(
   parameter int DATA_W = 32,
   parameter int REG_W  = 32,
   localparam int AMT_W = $clog2(DATA_W)
) (
   input  logic              from_reg_i,
   input  logic [AMT_W-1:0]  imm_i,
   input  logic [REG_W-1:0]  reg_i,
   output logic [AMT_W-1:0]  amt_o
);

   generate
      if (REG_W < AMT_W) begin : g_bad_reg_w
         $error("bsh_amt_sel: REG_W must hold at least AMT_W bits");
      end
   endgenerate

   // only the low AMT_W bits of the register select the amount
   assign amt_o = from_reg_i ? reg_i[AMT_W-1:0] : imm_i;

   always_comb begin
      if (from_reg_i) begin
         // R7
         reg_amt_trunc_chk: assert (amt_o == AMT_W'(reg_i % REG_W'(DATA_W)));
      end
   end

endmodule

// File: rtl/bsh_rotr.sv
`timescale 1ns/1ps
module bsh_rotr #(
   parameter int DATA_W = 32,
   localparam int AMT_W = $clog2(DATA_W)
) (
   input  logic [DATA_W-1:0] data_i,
   input  logic [AMT_W-1:0]  amt_i,
   output logic [DATA_W-1:0] rot_o
);

   logic [DATA_W-1:0] stg [AMT_W+1];

   assign stg[0] = data_i;

   // one stage per amount bit: stage s rotates right by 2**s when enabled
   generate
      for (genvar s = 0; s < AMT_W; s++) begin : g_stage
         localparam int STEP = 1 << s;
         assign stg[s+1] = amt_i[s] ? {stg[s][STEP-1:0], stg[s][DATA_W-1:STEP]}
                                    : stg[s];
      end
   endgenerate

   assign rot_o = stg[AMT_W];

endmodule

// File: rtl/bsh_fill.sv
`timescale 1ns/1ps
module bsh_fill
   import bsh_pkg::*;
#(
   parameter int DATA_W = 32,
   localparam int AMT_W = $clog2(DATA_W)
) (
   input  logic [DATA_W-1:0] data_i,
   input  logic [DATA_W-1:0] rot_i,
   input  logic [AMT_W-1:0]  amt_i,
   input  shift_kind_e       kind_i,
   input  logic              carry_i,
   output logic [DATA_W-1:0] result_o,
   output logic              carry_o
);

   logic [DATA_W-1:0] keep_mask;
   logic [DATA_W-1:0] masked;
   logic [DATA_W-1:0] masked_rev;
   logic              amt_zero;
   logic              last_out;

   // ones where bits survive a right shift of amt_i places
   assign keep_mask = {DATA_W{1'b1}} >> amt_i;
   assign masked    = rot_i & keep_mask;
   assign amt_zero  = (amt_i == '0);
   // after a right rotation by n, bit n-1 sits at the top
   assign last_out  = amt_zero ? carry_i : rot_i[DATA_W-1];

   generate
      for (genvar i = 0; i < DATA_W; i++) begin : g_rev
         assign masked_rev[i] = masked[DATA_W-1-i];
      end
   endgenerate

   always_comb begin
      result_o = data_i;
      carry_o  = carry_i;
      unique case (kind_i)
         SK_LSL: begin
            result_o = masked_rev;
            carry_o  = last_out;
         end
         SK_LSR: begin
            result_o = masked;
            carry_o  = last_out;
         end
         SK_ASR: begin
            result_o = masked | (data_i[DATA_W-1] ? ~keep_mask : '0);
            carry_o  = last_out;
         end
         SK_ROR: begin
            result_o = rot_i;
            carry_o  = last_out;
         end
         SK_RRX: begin
            result_o = {carry_i, data_i[DATA_W-1:1]};
            carry_o  = data_i[0];
         end
         default: begin
            result_o = data_i;
            carry_o  = carry_i;
         end
      endcase
   end

endmodule

// File: rtl/opnd_shifter.sv
`timescale 1ns/1ps
module opnd_shifter
   import bsh_pkg::*;
#(
   parameter int DATA_W = 32,
   parameter int REG_W  = 32,
   localparam int AMT_W = $clog2(DATA_W)
) (
   input  logic [DATA_W-1:0] data_i,
   input  logic [2:0]        kind_i,
   input  logic              amt_from_reg_i,
   input  logic [AMT_W-1:0]  amt_imm_i,
   input  logic [REG_W-1:0]  amt_reg_i,
   input  logic              carry_i,
   output logic [DATA_W-1:0] result_o,
   output logic              carry_o
);

   generate
      if (DATA_W < 2 || (DATA_W & (DATA_W - 1)) != 0) begin : g_bad_w
         $error("opnd_shifter: DATA_W must be a power of two, at least 2");
      end
   endgenerate

   shift_kind_e       kind;
   logic [AMT_W-1:0]  amt;
   logic [DATA_W-1:0] data_rev;
   logic [DATA_W-1:0] rot_in;
   logic [DATA_W-1:0] rot_out;

   assign kind = shift_kind_e'(kind_i);

   bsh_amt_sel #(.DATA_W(DATA_W), .REG_W(REG_W)) u_amt (
      .from_reg_i (amt_from_reg_i),
      .imm_i      (amt_imm_i),
      .reg_i      (amt_reg_i),
      .amt_o      (amt)
   );

   // left shifts run through the right rotator on the bit-reversed word
   generate
      for (genvar i = 0; i < DATA_W; i++) begin : g_in_rev
         assign data_rev[i] = data_i[DATA_W-1-i];
      end
   endgenerate

   assign rot_in = (kind == SK_LSL) ? data_rev : data_i;

   bsh_rotr #(.DATA_W(DATA_W)) u_rot (
      .data_i (rot_in),
      .amt_i  (amt),
      .rot_o  (rot_out)
   );

   bsh_fill #(.DATA_W(DATA_W)) u_fill (
      .data_i   (data_i),
      .rot_i    (rot_out),
      .amt_i    (amt),
      .kind_i   (kind),
      .carry_i  (carry_i),
      .result_o (result_o),
      .carry_o  (carry_o)
   );

   always_comb begin
      if (kind_i == 3'd0) begin
         // R1
         lsl_low_zero_chk: assert ((result_o & ((DATA_W'(1) << amt) - DATA_W'(1))) == '0);
      end
      if (kind_i == 3'd1 && amt != '0) begin
         // R2
         lsr_top_clear_chk: assert (result_o[DATA_W-1] == 1'b0);
      end
      if (kind_i == 3'd2) begin
         // R3
         asr_sign_keep_chk: assert (result_o[DATA_W-1] == data_i[DATA_W-1]);
      end
      if (kind_i == 3'd3) begin
         // R4
         ror_ones_keep_chk: assert ($countones(result_o) == $countones(data_i));
      end
      if (kind_i == 3'd4) begin
         // R5
         rrx_carry_in_chk: assert (result_o[DATA_W-1] == carry_i && carry_o == data_i[0]);
      end
      if (kind_i < 3'd4 && amt == '0) begin
         // R6
         zero_amt_pass_chk: assert (result_o == data_i && carry_o == carry_i);
      end
      if (kind_i > 3'd4) begin
         // R8
         spare_code_pass_chk: assert (result_o == data_i && carry_o == carry_i);
      end
   end

endmodule

// File: tb/tb_opnd_shifter.sv
`timescale 1ns/1ps
module tb_opnd_shifter;

   logic        clk = 1'b0;
   logic [31:0] data_i = '0;
   logic [2:0]  kind_i = '0;
   logic        amt_from_reg_i = 1'b0;
   logic [4:0]  amt_imm_i = '0;
   logic [31:0] amt_reg_i = '0;
   logic        carry_i = 1'b0;
   logic [31:0] result_o;
   logic        carry_o;

   always #4 clk = ~clk;

   opnd_shifter dut (
      .data_i         (data_i),
      .kind_i         (kind_i),
      .amt_from_reg_i (amt_from_reg_i),
      .amt_imm_i      (amt_imm_i),
      .amt_reg_i      (amt_reg_i),
      .carry_i        (carry_i),
      .result_o       (result_o),
      .carry_o        (carry_o)
   );

   typedef struct {
      logic [31:0] exp_res;
      logic        exp_c;
      string       tag;
   } exp_t;

   exp_t q[$];
   int   n_chk = 0;
   int   n_err = 0;
   bit   done  = 0;

   // independent bit-by-bit reference
   function automatic void model(input logic [31:0] x, input int k, input int n,
                                 input logic c, output logic [31:0] r, output logic co);
      r  = x;
      co = c;
      case (k)
         0: if (n != 0) begin
               for (int i = 0; i < 32; i++) r[i] = (i >= n) ? x[i-n] : 1'b0;
               co = x[32-n];
            end
         1: if (n != 0) begin
               for (int i = 0; i < 32; i++) r[i] = (i + n < 32) ? x[i+n] : 1'b0;
               co = x[n-1];
            end
         2: if (n != 0) begin
               for (int i = 0; i < 32; i++) r[i] = (i + n < 32) ? x[i+n] : x[31];
               co = x[n-1];
            end
         3: if (n != 0) begin
               for (int i = 0; i < 32; i++) r[i] = x[(i+n)%32];
               co = x[n-1];
            end
         4: begin
               for (int i = 0; i < 31; i++) r[i] = x[i+1];
               r[31] = c;
               co = x[0];
            end
         default: ;
      endcase
   endfunction

   function automatic string tag_of(input int k, input int n);
      if (k > 4)            return "R8";
      if (k == 4)           return "R5";
      if (n == 0)           return "R6";
      if (k == 0)           return "R1";
      if (k == 1)           return "R2";
      if (k == 2)           return "R3";
      return "R4";
   endfunction

   task automatic drive(input logic [31:0] x, input int k, input logic src,
                        input logic [4:0] imm, input logic [31:0] rg,
                        input logic c, input string tag);
      exp_t e;
      int   n;
      @(posedge clk);
      data_i = x; kind_i = 3'(k); amt_from_reg_i = src;
      amt_imm_i = imm; amt_reg_i = rg; carry_i = c;
      n = src ? int'(rg[4:0]) : int'(imm);
      model(x, k, n, c, e.exp_res, e.exp_c);
      e.tag = tag;
      q.push_back(e);
   endtask

   // monitor: compares half a cycle after each drive
   always @(negedge clk) begin
      if (q.size() > 0) begin
         exp_t e;
         e = q.pop_front();
         n_chk++;
         if (result_o !== e.exp_res || carry_o !== e.exp_c) begin
            n_err++;
            $display("FAIL %s: result=%h carry=%b expected result=%h carry=%b",
                     e.tag, result_o, carry_o, e.exp_res, e.exp_c);
         end
      end
   end

   task automatic finish_run();
      if (!done) begin
         done = 1;
         $display("Result: errors=%0d of %0d checks", n_err, n_chk);
         $finish;
      end
   endtask

   initial begin
      #1600000;
      n_err++; n_chk++;
      $display("FAIL watchdog: run did not end, expected completion");
      finish_run();
   end

   initial begin
      logic [31:0] pats [5];
      int          amts [4];
      pats[0] = 32'h8000_0001; pats[1] = 32'hFFFF_FFFF; pats[2] = 32'h7FFF_FFFF;
      pats[3] = 32'h1234_5678; pats[4] = 32'h0000_0000;
      amts[0] = 0; amts[1] = 1; amts[2] = 2; amts[3] = 31;

      // idle state: all-zero inputs give zero outputs (R6)
      #2;
      n_chk++;
      if (result_o !== 32'h0 || carry_o !== 1'b0) begin
         n_err++;
         $display("FAIL R6: result=%h carry=%b expected result=00000000 carry=0",
                  result_o, carry_o);
      end

      // every kind code at amounts 0,1,2,31 (R1..R6, R8)
      for (int k = 0; k < 8; k++)
         for (int a = 0; a < 4; a++)
            for (int p = 0; p < 5; p++)
               for (int c = 0; c < 2; c++)
                  drive(pats[p], k, 1'b0, 5'(amts[a]), 32'hDEAD_BEEF, 1'(c), tag_of(k, amts[a]));

      // register source: upper bits ignored, immediate ignored (R7)
      for (int k = 0; k < 5; k++) begin
         drive(32'hC3A5_0F96, k, 1'b1, 5'd17, 32'hFFFF_FFE3, 1'b1, "R7");
         drive(32'hC3A5_0F96, k, 1'b1, 5'd9,  32'h0000_0003, 1'b1, "R7");
         drive(32'hC3A5_0F96, k, 1'b1, 5'd4,  32'hABCD_EF00, 1'b0, "R7");
         drive(32'hC3A5_0F96, k, 1'b0, 5'd3,  32'h0000_0011, 1'b0, "R7");
      end

      // combinational: outputs valid 1 ns after an input change (R9)
      for (int k = 0; k < 5; k++) begin
         logic [31:0] er;
         logic        ec;
         @(posedge clk);
         data_i = 32'h0F0F_1234; kind_i = 3'(k); amt_from_reg_i = 1'b0;
         amt_imm_i = 5'd5; carry_i = 1'b1;
         #1;
         model(32'h0F0F_1234, k, 5, 1'b1, er, ec);
         n_chk++;
         if (result_o !== er || carry_o !== ec) begin
            n_err++;
            $display("FAIL R9: result=%h carry=%b expected result=%h carry=%b",
                     result_o, carry_o, er, ec);
         end
      end

      wait (q.size() == 0);
      @(posedge clk);
      finish_run();
   end

endmodule